// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block holds a small group of independent down-counters, each 32 bits wide. Software reaches them through a simple register bus with byte addresses. One free-running divider serves every channel. Each channel picks one of five divider taps through its control word, and its counter drops by one on each tick of that tap while the channel's bit in a shared run register is set.

When a running counter is at zero and takes a tick, it loads the period held in its reload register and keeps counting. It also raises a sticky underflow flag. If the channel's interrupt enable is set, the flag drives the channel's own level interrupt line. Software can load the live counter directly to set the next count, and it can rewrite the reload register to change every later period. Software clears the flag by rewriting the control word with the flag bit at zero.

A parameter picks between two address layouts that differ only in their base offsets.

Top module: `countdown_timer_bank`

## Requirements
- R1: After reset the run register reads 0, every reload and counter register reads 0xFFFFFFFF, and every control word reads 0.
- R2: The run register is 8 bits wide and reads back as written. Bit N set lets channel N count. Bit N clear holds channel N's counter at its value.
- R3: In the default layout the run register is at byte offset 4 and channel N starts at 8 + 12*N. With the layout parameter set, the run register is at 2 and channel N starts at 4 + 12*N. Inside a channel, the reload register is at +0, the counter at +4 and the control word at +8. Any other address reads 0 and ignores writes.
- R4: Control bits [2:0] pick the count rate: 0 = input clock/4, 1 = /16, 2 = /64, 3 = /256, 4 = /1024. Codes 5, 6 and 7 count at /4.
- R5: On each tick of its tap, a running counter that is above zero decrements by one. A running counter at zero loads the reload value instead, and counting continues.
- R6: A bus write to the counter sets its value and takes priority over a tick in the same cycle. A write to the reload register changes only later reloads. Both writes work whether the channel is running or stopped.
- R7: The underflow flag is control bit 8. Every reload from zero sets it. A control write with bit 8 = 0 clears it, and a control write with bit 8 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write wins.
- R8: Each channel's interrupt output is a level equal to its flag AND its interrupt enable (control bit 5), updated on the same edge as those bits.
- R9: The control word reads back bits [2:0] and bit 5 as last written, with bit 8 as the flag. All other bits read 0.
- R10: Reset clears the shared divider, which then advances once per clock. Tap /D ticks on the edges where the number of clocks since reset, modulo D, equals D-1. A run-register write takes effect from the next edge. A read returns the register value from before its edge, valid one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wen_i | input | 1 | Write strobe, one cycle per write |
| bus_ren_i | input | 1 | Read strobe; data appears on the next cycle |
| bus_wdata_i | input | CNT_W | Write data; the control word and run register use its low bits |
| bus_rdata_o | output | CNT_W | Registered read data, zero-extended |
| irq_o | output | NUM_CH | Per-channel level interrupt |

## Verification
The clocked properties assume that every input is driven to a known value after reset and that at most one register is addressed per cycle. The counter properties exclude cycles that carry a counter write, because such a write legally overrides a tick.

The stimulus takes addresses only from the legal map, plus a few unmapped ones, with exactly one access per cycle. It keeps loaded counts small so that underflows, reloads and flag races happen often within the run.

// File: rtl/tbank_pkg.sv
package tbank_pkg;
  localparam int TAPS      = 5;
  localparam int TAP_STEP  = 2;
  localparam int RUN_W     = 8;
  localparam int CTL_W     = 16;
  localparam int SEL_W     = 3;
  localparam int IE_BIT    = 5;
  localparam int FLAG_BIT  = 8;
  localparam int OFS_RELOAD = 0;
  localparam int OFS_COUNT  = 4;
  localparam int OFS_CTRL   = 8;
  localparam int CH_STRIDE  = 12;

  function automatic int run_reg_offset(bit legacy);
    return legacy ? 2 : 4;
  endfunction

  function automatic int chan_offset(bit legacy, int n);
    return (legacy ? 4 : 8) + CH_STRIDE * n;
  endfunction
endpackage

// File: rtl/tbank_prescaler.sv
module tbank_prescaler
  import tbank_pkg::*;
#(
  parameter int NTAPS = TAPS,
  parameter int STEP  = TAP_STEP
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NTAPS-1:0] tick_o
);
  localparam int DIV_W = NTAPS * STEP;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + DIV_W'(1);
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    assign tick_o[k] = &div_q[STEP*(k+1)-1:0];
  end

  // R4: the fastest tap never ticks on two adjacent edges
  assert_tap_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/tbank_channel.sv
module tbank_channel
  import tbank_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NTAPS = TAPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [NTAPS-1:0] tick_i,
  input  logic             reload_we_i,
  input  logic             count_we_i,
  input  logic             ctrl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CTL_W-1:0] ctrl_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] reload_q, count_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q, irq_q;
  logic             tap, step, wrap, flag_d, ie_d;

  always_comb begin
    tap = tick_i[0];
    for (int k = 1; k < NTAPS; k++)
      if (sel_q == SEL_W'(k)) tap = tick_i[k];
  end

  assign step   = run_i & tap;
  assign wrap   = step & (count_q == '0);
  assign ie_d   = ctrl_we_i ? wdata_i[IE_BIT] : ie_q;
  assign flag_d = wrap | (flag_q & ~(ctrl_we_i & ~wdata_i[FLAG_BIT]));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      count_q  <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (reload_we_i) reload_q <= wdata_i;
      if (count_we_i)  count_q  <= wdata_i;
      else if (wrap)   count_q  <= reload_q;
      else if (step)   count_q  <= count_q - CNT_W'(1);
      if (ctrl_we_i)   sel_q    <= wdata_i[SEL_W-1:0];
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & ie_d;
    end
  end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[SEL_W-1:0] = sel_q;
    ctrl_o[IE_BIT]   = ie_q;
    ctrl_o[FLAG_BIT] = flag_q;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign irq_o    = irq_q;

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !count_we_i) |=> $stable(count_q));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (rst)
    (step && count_q != '0 && !count_we_i) |=> count_q == $past(count_q) - CNT_W'(1));

  assert_reload_on_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (step && count_q == '0 && !count_we_i) |=> (count_q == $past(reload_q)) && flag_q);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(ctrl_we_i && !wdata_i[FLAG_BIT])) |=> flag_q);

  assert_flag_needs_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !step) |=> !flag_q);

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && ie_q));
endmodule

// File: rtl/tbank_decode.sv
module tbank_decode
  import tbank_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 7,
  parameter bit LEGACY = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         wen_i,
  input  logic                         ren_i,
  input  logic [CNT_W-1:0]             wdata_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] reload_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] count_i,
  input  logic [NUM_CH-1:0][CTL_W-1:0] ctrl_i,
  output logic [RUN_W-1:0]             run_o,
  output logic [NUM_CH-1:0]            reload_we_o,
  output logic [NUM_CH-1:0]            count_we_o,
  output logic [NUM_CH-1:0]            ctrl_we_o,
  output logic [CNT_W-1:0]             rdata_o
);
  localparam int RUN_ADDR = run_reg_offset(LEGACY);

  logic              hit_run;
  logic [NUM_CH-1:0] hit_reload, hit_count, hit_ctrl;
  logic [RUN_W-1:0]  run_q;
  logic [CNT_W-1:0]  rd_mux, rdata_q;

  assign hit_run = (addr_i == ADDR_W'(RUN_ADDR));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
    localparam int BASE = chan_offset(LEGACY, n);
    assign hit_reload[n] = (addr_i == ADDR_W'(BASE + OFS_RELOAD));
    assign hit_count[n]  = (addr_i == ADDR_W'(BASE + OFS_COUNT));
    assign hit_ctrl[n]   = (addr_i == ADDR_W'(BASE + OFS_CTRL));
  end

  assign reload_we_o = hit_reload & {NUM_CH{wen_i}};
  assign count_we_o  = hit_count  & {NUM_CH{wen_i}};
  assign ctrl_we_o   = hit_ctrl   & {NUM_CH{wen_i}};

  always_comb begin
    rd_mux = '0;
    if (hit_run) rd_mux = CNT_W'(run_q);
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit_reload[n]) rd_mux = reload_i[n];
      if (hit_count[n])  rd_mux = count_i[n];
      if (hit_ctrl[n])   rd_mux = CNT_W'(ctrl_i[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wen_i && hit_run) run_q <= wdata_i[RUN_W-1:0];
      if (ren_i) rdata_q <= rd_mux;
    end
  end

  assign run_o   = run_q;
  assign rdata_o = rdata_q;

  assert_single_target_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_run, hit_reload, hit_count, hit_ctrl}));

  assert_run_update_R10: assert property (@(posedge clk) disable iff (rst)
    !(wen_i && hit_run) |=> $stable(run_q));
endmodule

// File: rtl/countdown_timer_bank.sv
module countdown_timer_bank
  import tbank_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 7,
  parameter bit LEGACY_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wen_i,
  input  logic              bus_ren_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [TAPS-1:0]             tick;
  logic [RUN_W-1:0]            run;
  logic [NUM_CH-1:0]           reload_we, count_we, ctrl_we;
  logic [NUM_CH-1:0][CNT_W-1:0] reload_v, count_v;
  logic [NUM_CH-1:0][CTL_W-1:0] ctrl_v;

  tbank_prescaler #(.NTAPS(TAPS), .STEP(TAP_STEP)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  tbank_decode #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .LEGACY (LEGACY_MAP)
  ) u_decode (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (bus_addr_i),
    .wen_i       (bus_wen_i),
    .ren_i       (bus_ren_i),
    .wdata_i     (bus_wdata_i),
    .reload_i    (reload_v),
    .count_i     (count_v),
    .ctrl_i      (ctrl_v),
    .run_o       (run),
    .reload_we_o (reload_we),
    .count_we_o  (count_we),
    .ctrl_we_o   (ctrl_we),
    .rdata_o     (bus_rdata_o)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    tbank_channel #(.CNT_W(CNT_W), .NTAPS(TAPS)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .run_i       (run[n]),
      .tick_i      (tick),
      .reload_we_i (reload_we[n]),
      .count_we_i  (count_we[n]),
      .ctrl_we_i   (ctrl_we[n]),
      .wdata_i     (bus_wdata_i),
      .reload_o    (reload_v[n]),
      .count_o     (count_v[n]),
      .ctrl_o      (ctrl_v[n]),
      .irq_o       (irq_o[n])
    );
  end
endmodule

// File: tb/test_countdown_timer_bank.sv
`timescale 1ns/1ps
module test_countdown_timer_bank;
  localparam int NCH = 3;
  localparam int AW  = 7;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic wen = 1'b0, ren = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] irq;

  logic [AW-1:0] lg_addr = '0;
  logic lg_wen = 1'b0, lg_ren = 1'b0;
  logic [DW-1:0] lg_wdata = '0;
  logic [DW-1:0] lg_rdata;
  logic [NCH-1:0] lg_irq;

  always #10 clk = ~clk;

  countdown_timer_bank #(.NUM_CH(NCH), .CNT_W(DW), .ADDR_W(AW), .LEGACY_MAP(1'b0)) i_countdown_timer_bank (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wen_i(wen), .bus_ren_i(ren),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  countdown_timer_bank #(.NUM_CH(NCH), .CNT_W(DW), .ADDR_W(AW), .LEGACY_MAP(1'b1)) i_countdown_timer_bank_legacy (
    .clk(clk), .rst(rst), .bus_addr_i(lg_addr), .bus_wen_i(lg_wen), .bus_ren_i(lg_ren),
    .bus_wdata_i(lg_wdata), .bus_rdata_o(lg_rdata), .irq_o(lg_irq));

  // reference model built from the requirements
  int unsigned m_div;
  logic [7:0]  m_run;
  logic [31:0] m_reload [NCH];
  logic [31:0] m_count  [NCH];
  logic [2:0]  m_sel    [NCH];
  logic        m_ie     [NCH];
  logic        m_flag   [NCH];
  logic        m_irq    [NCH];

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_tag = "";

  function automatic int ch_addr(int n, int ofs);
    return 8 + 12 * n + ofs;
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (a == AW'(4)) r = {24'b0, m_run};
    for (int n = 0; n < NCH; n++) begin
      if (a == AW'(ch_addr(n, 0))) r = m_reload[n];
      if (a == AW'(ch_addr(n, 4))) r = m_count[n];
      if (a == AW'(ch_addr(n, 8))) r = {16'b0, 7'b0, m_flag[n], 2'b0, m_ie[n], 2'b0, m_sel[n]};
    end
    return r;
  endfunction

  function automatic bit tap_hit(int unsigned d, int k);
    int unsigned div = 4 ** (k + 1);
    return ((d + 1) % div) == 0;
  endfunction

  task automatic model_reset();
    m_div = 0; m_run = '0;
    for (int n = 0; n < NCH; n++) begin
      m_reload[n] = '1; m_count[n] = '1; m_sel[n] = '0;
      m_ie[n] = 0; m_flag[n] = 0; m_irq[n] = 0;
    end
  endtask

  task automatic model_update();
    for (int n = 0; n < NCH; n++) begin
      int kk;
      bit t, uf, nf, ni;
      logic [31:0] nc;
      kk = (m_sel[n] < 3'd5) ? int'(m_sel[n]) : 0;
      t  = m_run[n] && tap_hit(m_div, kk);
      uf = t && (m_count[n] == 0);
      nc = m_count[n];
      if (uf) nc = m_reload[n];
      else if (t) nc = m_count[n] - 1;
      if (wen && addr == AW'(ch_addr(n, 4))) nc = wdata;
      if (wen && addr == AW'(ch_addr(n, 0))) m_reload[n] = wdata;
      nf = m_flag[n]; ni = m_ie[n];
      if (wen && addr == AW'(ch_addr(n, 8))) begin
        m_sel[n] = wdata[2:0];
        ni = wdata[5];
        if (!wdata[8]) nf = 0;
      end
      if (uf) nf = 1;
      m_count[n] = nc; m_flag[n] = nf; m_ie[n] = ni;
      m_irq[n] = nf & ni;
    end
    if (wen && addr == AW'(4)) m_run = wdata[7:0];
    m_div++;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: inputs are set before the call, outputs checked after the edge
  task automatic cycle();
    bit rdp;
    logic [31:0] rexp;
    rdp  = ren;
    rexp = model_read(addr);
    @(posedge clk);
    model_update();
    @(negedge clk);
    if (rdp) check(cur_tag, rdata, rexp);
    for (int n = 0; n < NCH; n++) check("R8 irq", {31'b0, irq[n]}, {31'b0, m_irq[n]});
    wen = 0; ren = 0; lg_wen = 0; lg_ren = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = AW'(a); wdata = d; wen = 1; cycle();
  endtask

  task automatic rd(int a, string tag);
    cur_tag = tag; addr = AW'(a); ren = 1; cycle();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(4, "R1 run");
    for (int n = 0; n < NCH; n++) begin
      rd(ch_addr(n, 0), "R1 reload");
      rd(ch_addr(n, 4), "R1 count");
      rd(ch_addr(n, 8), "R1 ctrl");
    end

    // R3 unmapped addresses
    rd(0, "R3 unmapped");
    rd(5, "R3 unmapped");
    wr(3, 32'hFFFF_FFFF);
    rd(4, "R3 unmapped write");
    rd(ch_addr(NCH, 0), "R3 past last channel");

    // R3 alternate layout on the second instance
    lg_addr = 7'd2; lg_wdata = 32'hA5; lg_wen = 1; cycle();
    lg_addr = 7'd2; lg_ren = 1; cycle();
    check("R3 legacy run", lg_rdata, 32'h0000_00A5);
    lg_addr = 7'd16; lg_wdata = 32'h1234; lg_wen = 1; cycle();
    lg_addr = 7'd16; lg_ren = 1; cycle();
    check("R3 legacy reload ch1", lg_rdata, 32'h0000_1234);
    lg_addr = 7'd4; lg_ren = 1; cycle();
    check("R3 legacy reload ch0", lg_rdata, 32'hFFFF_FFFF);
    lg_addr = 7'd12; lg_ren = 1; cycle();
    check("R3 legacy ctrl ch0", lg_rdata, 32'h0);

    // R10 start timing and first countdown
    wr(ch_addr(0, 8), 32'h0);
    wr(ch_addr(0, 4), 32'd5);
    wr(ch_addr(0, 0), 32'd3);
    wr(4, 32'h1);
    for (int i = 0; i < 40; i++) rd(ch_addr(0, 4), "R10");
    for (int i = 0; i < 20; i++) rd(ch_addr(0, 4), "R5");

    // R7 flag behaviour with interrupt enabled
    wr(ch_addr(0, 8), 32'h20);
    idle(20);
    rd(ch_addr(0, 8), "R7 set");
    wr(ch_addr(0, 8), 32'h120);
    rd(ch_addr(0, 8), "R7 write one");
    wr(ch_addr(0, 8), 32'h020);
    rd(ch_addr(0, 8), "R7 clear");
    idle(30);
    rd(ch_addr(0, 8), "R7 reset again");

    // R4 each rate code on channel 1
    for (int code = 0; code < 8; code++) begin
      wr(ch_addr(1, 8), 32'(code));
      wr(ch_addr(1, 4), 32'd1000);
      wr(4, 32'h3);
      idle(code == 4 ? 2100 : 300);
      rd(ch_addr(1, 4), "R4");
    end

    // R2 freeze and run register width
    wr(4, 32'h1);
    rd(ch_addr(1, 4), "R2 frozen");
    idle(50);
    rd(ch_addr(1, 4), "R2 frozen later");
    wr(4, 32'hF9);
    rd(4, "R2 width");

    // R6 writes while running on channel 2
    wr(ch_addr(2, 0), 32'd7);
    wr(ch_addr(2, 4), 32'd2);
    wr(ch_addr(2, 8), 32'h0);
    wr(4, 32'h4);
    for (int i = 0; i < 40; i++) rd(ch_addr(2, 4), "R6");
    wr(ch_addr(2, 4), 32'd10);
    for (int i = 0; i < 20; i++) rd(ch_addr(2, 4), "R6 count write");
    wr(ch_addr(2, 0), 32'd1);
    for (int i = 0; i < 60; i++) rd(ch_addr(2, 4), "R6 reload write");

    // R9 control readback mask
    wr(ch_addr(2, 8), 32'h0000_FFFF);
    rd(ch_addr(2, 8), "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int sel, n, reg_i;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      n = $urandom_range(0, NCH - 1);
      reg_i = $urandom_range(0, 2) * 4;
      if (sel < 3) begin
        if (reg_i == 8) d = $urandom_range(0, 16'hFFFF);
        else if ($urandom_range(0, 7) == 0) d = $urandom;
        else d = $urandom_range(0, 40);
        if ($urandom_range(0, 5) == 0) wr(4, $urandom_range(0, 255));
        else wr(ch_addr(n, reg_i), d);
      end else if (sel < 7) begin
        if ($urandom_range(0, 9) == 0) rd(4, "R2 random");
        else if ($urandom_range(0, 19) == 0) rd(1, "R3 random");
        else if (reg_i == 0) rd(ch_addr(n, 0), "R6 random");
        else if (reg_i == 4) rd(ch_addr(n, 4), "R5 random");
        else rd(ch_addr(n, 8), "R9 random");
      end else begin
        cycle();
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule